// File: doc/BRIEF.md
# Echo Canceller Coefficient-Transfer Controller

This block holds the decision logic of a two-path echo canceller. Every cycle in which `smp_vld` is high it takes one sample from each of four streams: the far-end reference, the near-end send input, the background-filter error and the foreground-filter error. For each stream it adds up the squares of the samples over fixed windows of 2^LOG_LEN valid samples. The resulting short-time powers are compared at the close of each window. Cycles in which `smp_vld` is low are skipped.

At the close of a window the block weighs three power conditions. First, the background error must beat the foreground error by the ratio `alpha_q`. Second, the background error must beat the send input by the ratio `beta_q`. Third, the send input must be weaker than the reference. When all three hold and no double-talk hangover is running, the block raises a single-cycle strobe that tells the filters to copy coefficients. When the send input is stronger than the reference, the block raises a double-talk flag. The flag stays up for a programmable number of further windows and blocks transfers while it is up. The non-linear processor is gated off while the flag is up. The processor runs in an aggressive mode until a programmable number of transfers has been counted.

Top module: `echo_xfer_ctrl`

## Requirements
- R1: Each window's power for a stream is the sum of the squares of its 2^LOG_LEN valid samples, read as 16-bit two's complement. The decision at the close of a window uses that window's sums only, and all four sums restart at zero for the next window.
- R2: Condition one is 256·Pb < alpha_q·Pf. The comparison is exact, alpha_q is unsigned Q0.8, and equality fails the condition.
- R3: Condition two is 256·Pb < beta_q·Py. The comparison is exact, beta_q is unsigned Q0.8, and equality fails the condition.
- R4: Condition three is Py < Px. `xfer_stb` is high for exactly the one cycle after the clock edge that takes in the last sample of a window. It rises only when all three conditions hold and no hangover is running.
- R5: A window closing with Py > Px loads the hangover count with `hang_len` and raises `dt_flag`. The flag stays up through the next `hang_len` windows, and no transfer can happen while it is up. Py = Px counts neither as double-talk nor as condition three.
- R6: `nlp_en` is low whenever `dt_flag` is high, and high otherwise.
- R7: `nlp_aggr` is high until the number of transfer strobes reaches `conv_target`. It drops one cycle after the strobe that reaches the count and then stays low until reset. With `conv_target` = 0 it drops right after reset.
- R8: A synchronous active-high `rst` clears the window sums, the sample count, the hangover, the flag, the strobe, the transfer count and the convergence state.
- R9: Input values present while `smp_vld` is low change no sum and no output.
- R10: Full-scale samples of -32768 and 32767 produce exact sums and products with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One sample per stream is present |
| x_in | input | SW | Far-end reference sample, signed |
| y_in | input | SW | Near-end send sample, signed |
| eb_in | input | SW | Background-filter error sample, signed |
| ef_in | input | SW | Foreground-filter error sample, signed |
| alpha_q | input | 8 | Ratio for condition one, Q0.8 |
| beta_q | input | 8 | Ratio for condition two, Q0.8 |
| hang_len | input | HW | Hangover length in windows |
| conv_target | input | CW | Transfer count that ends the aggressive mode |
| xfer_stb | output | 1 | Coefficient transfer strobe |
| dt_flag | output | 1 | Double-talk flag, including hangover |
| nlp_en | output | 1 | Non-linear processor enable |
| nlp_aggr | output | 1 | Non-linear processor aggressive mode |

## Verification
The bench sweeps the background error across the exact point where 256·Pb equals the scaled foreground or send power. A design that rounded the ratio or used <= in place of < would then strobe on the equal-power step. It steps the send power through the reference power under hangover lengths 0 to 3. A design whose hangover counter is off by one freezes one window too many or too few, and a design that treats equal powers as double-talk raises the flag. Between windows the inputs carry large junk values while the valid input is low, so a design that counts them raises a false double-talk. A reset in the middle of a window, followed by a clean window, catches sums that survive reset, and full-scale samples catch sums that are too narrow.

// File: rtl/echo_xfer_ctrl.sv
module echo_xfer_ctrl #(
  parameter int SW      = 16,
  parameter int LOG_LEN = 4,
  parameter int HW      = 8,
  parameter int CW      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] x_in,
  input  logic signed [SW-1:0] y_in,
  input  logic signed [SW-1:0] eb_in,
  input  logic signed [SW-1:0] ef_in,
  input  logic [7:0]           alpha_q,
  input  logic [7:0]           beta_q,
  input  logic [HW-1:0]        hang_len,
  input  logic [CW-1:0]        conv_target,
  output logic                 xfer_stb,
  output logic                 dt_flag,
  output logic                 nlp_en,
  output logic                 nlp_aggr
);
  localparam int SQW = 2 * SW - 1;
  localparam int PW  = SQW + LOG_LEN;
  localparam int MW  = PW + 8;

  function automatic logic [SQW-1:0] sq(input logic signed [SW-1:0] s);
    logic signed [2*SW-1:0] p;
    p = s * s;
    return p[SQW-1:0];
  endfunction

  logic [LOG_LEN-1:0] cnt;
  logic [PW-1:0]      acc_x, acc_y, acc_b, acc_f;
  logic [HW-1:0]      hold;
  logic [CW-1:0]      n_xfer;
  logic               conv;

  wire          last = smp_vld && (cnt == '1);
  wire [PW-1:0] px   = acc_x + PW'(sq(x_in));
  wire [PW-1:0] py   = acc_y + PW'(sq(y_in));
  wire [PW-1:0] pb   = acc_b + PW'(sq(eb_in));
  wire [PW-1:0] pf   = acc_f + PW'(sq(ef_in));

  wire [MW-1:0] b_scaled = {pb, 8'd0};
  wire [MW-1:0] f_scaled = MW'(pf) * MW'(alpha_q);
  wire [MW-1:0] y_scaled = MW'(py) * MW'(beta_q);

  wire cond_a   = b_scaled < f_scaled;
  wire cond_b   = b_scaled < y_scaled;
  wire cond_c   = py < px;
  wire dt_now   = py > px;
  wire frozen   = hold != '0;
  wire xfer_now = cond_a && cond_b && cond_c && !frozen;
  wire [HW-1:0] hold_nx = dt_now ? hang_len : (frozen ? hold - 1'b1 : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc_x    <= '0;
      acc_y    <= '0;
      acc_b    <= '0;
      acc_f    <= '0;
      hold     <= '0;
      n_xfer   <= '0;
      conv     <= 1'b0;
      dt_flag  <= 1'b0;
      xfer_stb <= 1'b0;
    end else begin
      xfer_stb <= last && xfer_now;
      conv     <= conv || (n_xfer >= conv_target);
      if (smp_vld) begin
        cnt   <= cnt + 1'b1;
        acc_x <= last ? '0 : px;
        acc_y <= last ? '0 : py;
        acc_b <= last ? '0 : pb;
        acc_f <= last ? '0 : pf;
      end
      if (last) begin
        hold    <= hold_nx;
        dt_flag <= dt_now || (hold_nx != '0);
        if (xfer_now && !conv) n_xfer <= n_xfer + 1'b1;
      end
    end
  end

  assign nlp_en   = !dt_flag;
  assign nlp_aggr = !conv;
endmodule

module echo_xfer_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic smp_vld,
  input logic xfer_stb,
  input logic dt_flag,
  input logic nlp_aggr
);
  // R4
  xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |=> !xfer_stb);
  // R5
  xfer_not_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> !dt_flag);
  // R9
  xfer_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !rst) |=> !xfer_stb);
  // R9
  dt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !rst) |=> $stable(dt_flag));
  // R7
  conv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!nlp_aggr && !rst) |=> !nlp_aggr);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!xfer_stb && !dt_flag && nlp_aggr));
endmodule

bind echo_xfer_ctrl echo_xfer_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld),
  .xfer_stb(xfer_stb), .dt_flag(dt_flag), .nlp_aggr(nlp_aggr)
);

// File: tb/sim_echo_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_echo_xfer_ctrl;
  localparam int LL = 2;
  localparam int NS = 1 << LL;

  logic clk = 0, rst = 1, smp_vld = 0;
  logic signed [15:0] x_in = 0, y_in = 0, eb_in = 0, ef_in = 0;
  logic [7:0] alpha_q = 64, beta_q = 255;
  logic [3:0] hang_len = 2, conv_target = 3;
  logic xfer_stb, dt_flag, nlp_en, nlp_aggr;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_hc = 0, m_cc = 0;
  bit m_conv = 0;

  echo_xfer_ctrl #(.SW(16), .LOG_LEN(LL), .HW(4), .CW(4)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .x_in(x_in), .y_in(y_in),
    .eb_in(eb_in), .ef_in(ef_in), .alpha_q(alpha_q), .beta_q(beta_q),
    .hang_len(hang_len), .conv_target(conv_target), .xfer_stb(xfer_stb),
    .dt_flag(dt_flag), .nlp_en(nlp_en), .nlp_aggr(nlp_aggr));

  always #2 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sv(int v, int k);
    return (k % 2 == 1 && v != -32768) ? -v : v;
  endfunction

  task automatic junk();
    x_in = 0; y_in = 32767; eb_in = 32767; ef_in = 0;
  endtask

  task automatic interval(string tag, int vx, int vy, int vb, int vf);
    longint px = 0, py = 0, pb = 0, pf = 0;
    bit c1, c2, c3, dtn, frz, ex, edt;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      smp_vld = 1;
      x_in = 16'(sv(vx, k)); y_in = 16'(sv(vy, k));
      eb_in = 16'(sv(vb, k)); ef_in = 16'(sv(vf, k));
      px += longint'(sv(vx, k)) * sv(vx, k);
      py += longint'(sv(vy, k)) * sv(vy, k);
      pb += longint'(sv(vb, k)) * sv(vb, k);
      pf += longint'(sv(vf, k)) * sv(vf, k);
    end
    c1 = 256 * pb < longint'(alpha_q) * pf;
    c2 = 256 * pb < longint'(beta_q) * py;
    c3 = py < px;
    dtn = py > px;
    frz = m_hc != 0;
    ex = c1 && c2 && c3 && !frz;
    m_hc = dtn ? int'(hang_len) : (frz ? m_hc - 1 : 0);
    edt = dtn || m_hc != 0;
    if (ex && !m_conv) m_cc++;
    @(posedge clk); #1;
    check({tag, " xfer_stb"}, xfer_stb, ex);
    check("R5 dt_flag", dt_flag, edt);
    check("R6 nlp_en", nlp_en, !edt);
    @(negedge clk);
    smp_vld = 0; junk();
    m_conv = m_conv || (m_cc >= int'(conv_target));
    @(posedge clk); #1;
    check("R4 strobe width", xfer_stb, 0);
    check("R7 nlp_aggr", nlp_aggr, !m_conv);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset xfer", xfer_stb, 0);
    check("R8 reset dt", dt_flag, 0);
    check("R8 reset nlp_en", nlp_en, 1);
    check("R8 reset aggr", nlp_aggr, 1);
    @(negedge clk); rst = 0; junk();
    @(negedge clk);

    // R2 sweep across exact alpha boundary (eb=8 gives equality)
    for (int eb = 0; eb < 12; eb++) interval("R2", 30, 20, eb, 16);
    // R3 sweep across exact beta boundary
    alpha_q = 255; beta_q = 64;
    for (int eb = 0; eb < 12; eb++) interval("R3", 30, 16, eb, 100);
    // R4/R5 send power stepped through reference, hangover 0..3
    beta_q = 255;
    for (int h = 0; h < 4; h++) begin
      hang_len = 4'(h);
      interval("R5", 10, 12, 0, 5);
      for (int r = 0; r < 5; r++) interval("R5", 10, 9, 0, 5);
      interval("R4", 10, 10, 0, 5);
      for (int y = 8; y < 13; y++) interval("R4", 10, y, 1, 5);
    end
    // R10 full-scale samples
    hang_len = 0;
    interval("R10", -32768, 32767, 0, 1);
    interval("R10", 32767, -32768, 0, 1);
    interval("R10", -32768, 32767, 0, 1);

    // R1/R8 reset in mid-window, then a clean window with target 0
    hang_len = 2;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); smp_vld = 1; x_in = 0; y_in = 32767; eb_in = 32767; ef_in = 0;
    end
    @(negedge clk); smp_vld = 0; rst = 1; conv_target = 0;
    @(posedge clk); #1;
    check("R8 mid reset dt", dt_flag, 0);
    @(negedge clk); rst = 0;
    m_hc = 0; m_cc = 0; m_conv = 0;
    @(posedge clk); #1;
    m_conv = 1;
    check("R7 target zero", nlp_aggr, 0);
    @(negedge clk);
    interval("R1", 30, 20, 0, 16);
    interval("R1", 30, 20, 5, 16);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule